// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block sits behind the opcode fetch of an 8-bit processor with a 16-bit address space. A start pulse hands it an addressing-mode code, the choice of index register, the values of both index registers, and the address of the first byte after the opcode. It then reads the operand bytes it needs through a byte-wide memory port with a request/valid handshake. For indirect modes it also follows a pointer held in memory. Where the mode calls for it, it adds the selected index register. It finishes with a one-cycle done strobe that carries the effective address, the number of bytes taken after the opcode, and the updated program counter.

Multi-byte values are big-endian: the high byte sits at the lower address and is read first. The memory may stall for any number of cycles, and the block holds its request and address until valid arrives. A mode code outside the supported set raises a one-cycle error instead of done. A start pulse that arrives while the block is busy is ignored.

Top module: `ea_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, memReq, done and error are all 0.
- R2: Mode 0 (no operand bytes) ends with done one cycle after start, effAddr 0 and byteCount 0. Mode 4 (index register alone) ends the same way, with effAddr equal to the zero-extended selected index register. Neither mode raises memReq.
- R3: Mode 1 (immediate) reads one byte at pcIn. done then shows that byte in effAddr[7:0] with effAddr[15:8] zero, operandOnly 1 and byteCount 1. In every other mode operandOnly is 0 at done.
- R4: Mode 2 reads one byte at pcIn and gives effAddr {0x00, byte}. Mode 3 reads the high byte at pcIn and then the low byte at pcIn+1, and gives {high, low} with byteCount 2.
- R5: Mode 5 reads one offset byte at pcIn and gives effAddr = index + offset as a 9-bit unsigned sum (up to 0x1FE), with bits 15:9 zero.
- R6: Mode 6 reads a 16-bit offset, high byte first, and gives effAddr = (offset + index) mod 65536.
- R7: Mode 7 reads a pointer byte P at pcIn, then reads one byte at address {0x00, P}, which becomes effAddr[7:0] with the upper byte zero. byteCount is 1.
- R8: Mode 8 reads a pointer byte P at pcIn, then the high byte at {0x00, P} and the low byte at {0x00, P}+1, where that increment is 16-bit (P = 0xFF reads 0x00FF then 0x0100). byteCount is 1.
- R9: While memReq is high and memValid is low, memReq stays high and memAddr stays unchanged. done follows one cycle after the last accepted byte.
- R10: Operand bytes are read at pcIn, pcIn+1 with 16-bit wrap. At done, pcNext = pcIn + byteCount mod 65536.
- R11: idxSel 0 selects idxX and 1 selects idxY. Both are sampled only at the accepted start.
- R12: Mode codes 9 to 15 raise error for exactly one cycle, one cycle after start. They raise no done and no memReq.
- R13: start, mode and the index inputs are ignored while busy is high. The running operation ends with its original result.
- R14: done and error are each high for only one cycle at a time, and never together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation (taken when not busy) |
| mode | input | 4 | Addressing-mode code |
| idxSel | input | 1 | Index select: 0 = idxX, 1 = idxY |
| idxX | input | 8 | First index register value |
| idxY | input | 8 | Second index register value |
| pcIn | input | 16 | Address of the first byte after the opcode |
| memReq | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| memValid | input | 1 | Read data valid; completes the current request |
| memData | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| error | output | 1 | One-cycle unsupported-mode strobe |
| effAddr | output | 16 | Effective address (operand value in mode 1), valid with done |
| byteCount | output | 2 | Bytes consumed after the opcode, valid with done |
| pcNext | output | 16 | Program counter after the operand bytes, valid with done |
| operandOnly | output | 1 | Set at done when effAddr carries an immediate value |

## Verification
A request appears one cycle after the accepted start, and each later request follows one cycle after the previous accepted byte. done, or error for a bad code, is due one cycle after the last accepted byte. With no bytes to fetch, it is due one cycle after start. The bench builds the expected read-address list and the final result from the mode rules alone, serves the reads from its own memory model with a chosen number of stall cycles, and compares memReq, memAddr, done and error on every falling edge. The result fields are checked on the falling edge where done is due, and the edge after that must show done low and busy low.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2;

  localparam logic [3:0] M_INH  = 4'd0;
  localparam logic [3:0] M_IMM  = 4'd1;
  localparam logic [3:0] M_DIRS = 4'd2;
  localparam logic [3:0] M_DIRL = 4'd3;
  localparam logic [3:0] M_IDXN = 4'd4;
  localparam logic [3:0] M_IDXS = 4'd5;
  localparam logic [3:0] M_IDXL = 4'd6;
  localparam logic [3:0] M_INDB = 4'd7;
  localparam logic [3:0] M_INDW = 4'd8;

  typedef struct packed {
    logic init;
    logic takeHi;
    logic takeLo;
    logic takePtr;
    logic stepPc;
    logic stepPtr;
    logic usePtr;
  } dpCtl_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] modeIn,
  input  logic       memValid,
  output dpCtl_t     ctl,
  output logic [3:0] modeR,
  output logic       memReq,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic       operandOnly
);
  typedef enum logic [2:0] {S_IDLE, S_OP1, S_OP2, S_PT1, S_PT2, S_DONE, S_ERR} state_e;
  state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st    <= S_IDLE;
      modeR <= M_INH;
    end else begin
      st <= nxt;
      if (st == S_IDLE && start) modeR <= modeIn;
    end
  end

  always_comb begin
    ctl    = '0;
    nxt    = st;
    memReq = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        ctl.init = 1'b1;
        if (modeIn > M_INDW)                         nxt = S_ERR;
        else if (modeIn == M_INH || modeIn == M_IDXN) nxt = S_DONE;
        else                                           nxt = S_OP1;
      end
      S_OP1: begin
        memReq = 1'b1;
        if (memValid) begin
          ctl.stepPc = 1'b1;
          case (modeR)
            M_DIRL, M_IDXL: begin ctl.takeHi  = 1'b1; nxt = S_OP2; end
            M_INDB, M_INDW: begin ctl.takePtr = 1'b1; nxt = S_PT1; end
            default:        begin ctl.takeLo  = 1'b1; nxt = S_DONE; end
          endcase
        end
      end
      S_OP2: begin
        memReq = 1'b1;
        if (memValid) begin
          ctl.stepPc = 1'b1;
          ctl.takeLo = 1'b1;
          nxt        = S_DONE;
        end
      end
      S_PT1: begin
        memReq     = 1'b1;
        ctl.usePtr = 1'b1;
        if (memValid) begin
          if (modeR == M_INDW) begin
            ctl.takeHi  = 1'b1;
            ctl.stepPtr = 1'b1;
            nxt         = S_PT2;
          end else begin
            ctl.takeLo = 1'b1;
            nxt        = S_DONE;
          end
        end
      end
      S_PT2: begin
        memReq     = 1'b1;
        ctl.usePtr = 1'b1;
        if (memValid) begin
          ctl.takeLo = 1'b1;
          nxt        = S_DONE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_DONE);
  assign error       = (st == S_ERR);
  assign operandOnly = done && (modeR == M_IMM);
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [3:0]        modeR,
  input  logic              idxSel,
  input  logic [BYTE_W-1:0] idxX,
  input  logic [BYTE_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic [CNT_W-1:0]  byteCount,
  output logic [ADDR_W-1:0] pcNext
);
  localparam int HI_PAD = ADDR_W - BYTE_W;
  localparam int SUM_W  = BYTE_W + 1;

  logic [ADDR_W-1:0] pcR, ptrR;
  logic [BYTE_W-1:0] hiR, loR, idxR;
  logic [CNT_W-1:0]  cntR;
  logic [SUM_W-1:0]  shortSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcR  <= '0;
      ptrR <= '0;
      hiR  <= '0;
      loR  <= '0;
      idxR <= '0;
      cntR <= '0;
    end else begin
      if (ctl.init) begin
        pcR  <= pcIn;
        idxR <= idxSel ? idxY : idxX;
        hiR  <= '0;
        loR  <= '0;
        cntR <= '0;
      end
      if (ctl.stepPc) begin
        pcR  <= pcR + 1'b1;
        cntR <= cntR + 1'b1;
      end
      if (ctl.takePtr) ptrR <= {{HI_PAD{1'b0}}, memData};
      if (ctl.stepPtr) ptrR <= ptrR + 1'b1;
      if (ctl.takeHi)  hiR  <= memData;
      if (ctl.takeLo)  loR  <= memData;
    end
  end

  assign shortSum  = {1'b0, idxR} + {1'b0, loR};
  assign memAddr   = ctl.usePtr ? ptrR : pcR;
  assign byteCount = cntR;
  assign pcNext    = pcR;

  always_comb begin
    case (modeR)
      M_IMM, M_DIRS, M_INDB: effAddr = {{HI_PAD{1'b0}}, loR};
      M_DIRL, M_INDW:        effAddr = {hiR, loR};
      M_IDXN:                effAddr = {{HI_PAD{1'b0}}, idxR};
      M_IDXS:                effAddr = {{(ADDR_W-SUM_W){1'b0}}, shortSum};
      M_IDXL:                effAddr = {hiR, loR} + {{HI_PAD{1'b0}}, idxR};
      default:               effAddr = '0;
    endcase
  end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic        idxSel,
  input  logic [7:0]  idxX,
  input  logic [7:0]  idxY,
  input  logic [15:0] pcIn,
  output logic        memReq,
  output logic [15:0] memAddr,
  input  logic        memValid,
  input  logic [7:0]  memData,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic [15:0] effAddr,
  output logic [1:0]  byteCount,
  output logic [15:0] pcNext,
  output logic        operandOnly
);
  dpCtl_t     ctl;
  logic [3:0] modeR;

  ea_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(mode), .memValid(memValid),
    .ctl(ctl), .modeR(modeR), .memReq(memReq), .busy(busy), .done(done),
    .error(error), .operandOnly(operandOnly)
  );

  ea_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .modeR(modeR), .idxSel(idxSel),
    .idxX(idxX), .idxY(idxY), .pcIn(pcIn), .memData(memData),
    .memAddr(memAddr), .effAddr(effAddr), .byteCount(byteCount), .pcNext(pcNext)
  );
endmodule

// File: rtl/ea_sequencer_chk.sv
module ea_sequencer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [3:0]  mode,
  input logic        idxSel,
  input logic [7:0]  idxX,
  input logic [7:0]  idxY,
  input logic [15:0] pcIn,
  input logic        memReq,
  input logic [15:0] memAddr,
  input logic        memValid,
  input logic [7:0]  memData,
  input logic        busy,
  input logic        done,
  input logic        error,
  input logic [15:0] effAddr,
  input logic [1:0]  byteCount,
  input logic [15:0] pcNext,
  input logic        operandOnly
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr));

  // R14
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R14
  done_error_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  // R2
  zero_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (mode == 4'd0 || mode == 4'd4) |=> done && !memReq);

  // R12
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (mode > 4'd8) |=> error && !memReq && !done);

  // R3
  operand_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    operandOnly |-> done && effAddr[15:8] == 8'h00 && byteCount == 2'd1);
endmodule

bind ea_sequencer ea_sequencer_chk u_chk (.*);

// File: tb/test_ea_sequencer.sv
module test_ea_sequencer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, start, idxSel, memValid;
  logic [3:0]  mode;
  logic [7:0]  idxX, idxY, memData;
  logic [15:0] pcIn;
  logic        memReq, busy, done, error, operandOnly;
  logic [15:0] memAddr, effAddr, pcNext;
  logic [1:0]  byteCount;

  int nCmp = 0;
  int nBad = 0;
  logic [7:0] ovr [int];

  ea_sequencer i_ea_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .idxSel(idxSel),
    .idxX(idxX), .idxY(idxY), .pcIn(pcIn), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .busy(busy), .done(done),
    .error(error), .effAddr(effAddr), .byteCount(byteCount), .pcNext(pcNext),
    .operandOnly(operandOnly)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    if (ovr.exists(int'(a))) return ovr[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  task automatic run(input string req, input logic [3:0] m, input logic sel,
                     input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc,
                     input int stall, input bit poke);
    logic [15:0] q[$];
    logic [15:0] ea, p16;
    logic [7:0]  idx, b0, b1;
    int cnt;
    bit bad;
    idx = sel ? y : x;
    bad = 1'b0;
    cnt = 0;
    ea  = 16'h0000;
    b0  = mb(pc);
    b1  = mb(pc + 16'd1);
    p16 = {8'h00, b0};
    case (m)
      4'd0: begin end
      4'd1, 4'd2: begin q.push_back(pc); cnt = 1; ea = {8'h00, b0}; end
      4'd3: begin q.push_back(pc); q.push_back(pc + 16'd1); cnt = 2; ea = {b0, b1}; end
      4'd4: ea = {8'h00, idx};
      4'd5: begin q.push_back(pc); cnt = 1; ea = 16'({8'h00, idx} + {8'h00, b0}); end
      4'd6: begin q.push_back(pc); q.push_back(pc + 16'd1); cnt = 2; ea = 16'({b0, b1} + {8'h00, idx}); end
      4'd7: begin q.push_back(pc); q.push_back(p16); cnt = 1; ea = {8'h00, mb(p16)}; end
      4'd8: begin q.push_back(pc); q.push_back(p16); q.push_back(p16 + 16'd1); cnt = 1;
                  ea = {mb(p16), mb(p16 + 16'd1)}; end
      default: bad = 1'b1;
    endcase

    @(negedge clk);
    start = 1'b1; mode = m; idxSel = sel; idxX = x; idxY = y; pcIn = pc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R13: new start and different inputs while busy must be ignored
      start = 1'b1; mode = 4'hF; idxX = ~x; idxY = ~y; idxSel = ~sel; pcIn = ~pc;
    end
    if (bad) begin
      chk(req, "error", error, 1'b1);
      chk(req, "done", done, 1'b0);
      chk(req, "memReq", memReq, 1'b0);
      @(negedge clk);
      chk("R14", "error second cycle", error, 1'b0);
      chk(req, "busy after error", busy, 1'b0);
      return;
    end
    while (q.size() > 0) begin
      for (int s = 0; s < stall; s++) begin
        memValid = 1'b0;
        chk("R9", "memReq stalled", memReq, 1'b1);
        chk("R9", "memAddr stalled", memAddr, q[0]);
        chk("R9", "done stalled", done, 1'b0);
        @(negedge clk);
      end
      chk(req, "memReq", memReq, 1'b1);
      chk(req, "memAddr", memAddr, q[0]);
      chk(req, "done early", done, 1'b0);
      memValid = 1'b1;
      memData  = mb(q[0]);
      void'(q.pop_front());
      @(negedge clk);
      memValid = 1'b0;
      memData  = 8'hXX;
    end
    start = 1'b0;
    chk(req, "done", done, 1'b1);
    chk(req, "error", error, 1'b0);
    chk(req, "memReq at done", memReq, 1'b0);
    chk(req, "effAddr", effAddr, ea);
    chk("R10", "byteCount", byteCount, cnt[1:0]);
    chk("R10", "pcNext", pcNext, 16'(pc + cnt[15:0]));
    chk("R3", "operandOnly", operandOnly, (m == 4'd1));
    @(negedge clk);
    chk("R14", "done one cycle", done, 1'b0);
    chk(req, "busy after done", busy, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rstN = 1'b0; start = 1'b0; mode = 4'd0; idxSel = 1'b0; idxX = 8'h00; idxY = 8'h00;
    pcIn = 16'h0000; memValid = 1'b0; memData = 8'h00;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "busy in reset", busy, 1'b0);
    chk("R1", "memReq in reset", memReq, 1'b0);
    chk("R1", "done in reset", done, 1'b0);
    chk("R1", "error in reset", error, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "memReq after reset", memReq, 1'b0);

    ovr[16'h0400] = 8'hFF;
    ovr[16'h2000] = 8'hFF; ovr[16'h2001] = 8'hF0;
    ovr[16'h3000] = 8'h55; ovr[16'h0055] = 8'hA7;
    ovr[16'h3100] = 8'hFF; ovr[16'h00FF] = 8'h12; ovr[16'h0100] = 8'h34;

    run("R2", 4'd0, 1'b0, 8'h11, 8'h22, 16'h1000, 0, 1'b0);
    run("R2", 4'd4, 1'b0, 8'h7E, 8'h22, 16'h1000, 0, 1'b0);
    run("R11", 4'd4, 1'b1, 8'h7E, 8'hC3, 16'h1000, 0, 1'b0);
    run("R3", 4'd1, 1'b0, 8'h00, 8'h00, 16'h1234, 0, 1'b0);
    run("R4", 4'd2, 1'b0, 8'h00, 8'h00, 16'h4321, 1, 1'b0);
    run("R4", 4'd3, 1'b0, 8'h00, 8'h00, 16'h5A10, 2, 1'b0);
    run("R5", 4'd5, 1'b0, 8'hFF, 8'h01, 16'h0400, 0, 1'b0);
    run("R11", 4'd5, 1'b1, 8'hFF, 8'h01, 16'h0400, 0, 1'b0);
    run("R6", 4'd6, 1'b1, 8'h00, 8'h20, 16'h2000, 0, 1'b0);
    run("R7", 4'd7, 1'b0, 8'h00, 8'h00, 16'h3000, 1, 1'b0);
    run("R8", 4'd8, 1'b0, 8'h00, 8'h00, 16'h3100, 0, 1'b0);
    run("R10", 4'd3, 1'b0, 8'h00, 8'h00, 16'hFFFF, 0, 1'b0);
    run("R9", 4'd8, 1'b0, 8'h00, 8'h00, 16'h3100, 3, 1'b0);
    run("R13", 4'd6, 1'b0, 8'h40, 8'h09, 16'h2000, 1, 1'b1);
    run("R12", 4'hB, 1'b0, 8'h00, 8'h00, 16'h0000, 0, 1'b0);
    run("R12", 4'h9, 1'b0, 8'h00, 8'h00, 16'h0000, 0, 1'b0);
    run("R2", 4'd0, 1'b0, 8'h00, 8'h00, 16'h0010, 0, 1'b0);
    summary();
  end
endmodule